// File: doc/BRIEF.md
# Ripple Bit-Slice ALU with Operand Conditioning and Shifts

This block is a 16-bit arithmetic and logic unit made from a row of identical one-bit slices. Each slice first conditions its two operand bits: it can force either operand to zero through an enable control and can invert it through an invert control. From the conditioned bits it forms four logic results, a full-adder sum, a left-shifted bit and a right-shifted bit. A 3-bit function code then picks one of these as the slice output.

The carry runs from bit 0 up to bit 15. The left-shift path also moves upward. The right-shift path runs from bit 15 down to bit 0, and bit 15 takes an external shift-in bit. The unit is purely combinational. Any change on an input appears on the result and the carry-out in the same cycle, so a datapath can place it between its own registers. Arithmetic functions the code does not select directly are built by choosing the controls. For example, A AND NOT B can be formed in two different ways. No setting of the controls gives a bitwise XOR.

Top module: `bitslice_alu`

## Requirements
- R1: Each slice conditions its operands as A' = (A AND op_a_en) XOR op_a_inv and B' = (B AND op_b_en) XOR op_b_inv. Every function code acts on A' and B', never on the raw A and B.
- R2: Function code 3'b000 (bit 2 most significant) gives result = A' AND B'.
- R3: Function codes 3'b001, 3'b010 and 3'b011 give A' OR B', A' NAND B' and A' NOR B' respectively.
- R4: Function code 3'b101 gives the 16-bit sum A' + B' + carry_in. The carry enters only bit 0 and ripples through every slice.
- R5: For every function code, carry_out equals the carry out of bit 15 of the addition A' + B' + carry_in.
- R6: Function code 3'b100 gives B' shifted left by one place, with 0 in result bit 0. With op_b_en=1 and op_b_inv=0 this is B times 2, modulo 2^16.
- R7: Function code 3'b110 gives A' shifted right by one place, with rshift_in in result bit 15. With rshift_in=0, op_a_en=1 and op_a_inv=0 this is a logical right shift of A.
- R8: Function code 3'b111 passes A' to the result unchanged.
- R9: A AND NOT B is produced both by code 3'b000 with op_a_en=1, op_a_inv=0, op_b_en=1, op_b_inv=1, and by code 3'b011 with op_a_en=1, op_a_inv=1, op_b_en=1, op_b_inv=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | Operand A |
| b | input | 16 | Operand B |
| op_a_en | input | 1 | Passes A when 1; forces it to 0 when 0 |
| op_a_inv | input | 1 | Inverts the gated A when 1 |
| op_b_en | input | 1 | Passes B when 1; forces it to 0 when 0 |
| op_b_inv | input | 1 | Inverts the gated B when 1 |
| carry_in | input | 1 | Carry into bit 0 |
| rshift_in | input | 1 | Bit shifted into bit 15 for a right shift |
| func_sel | input | 3 | Function code; bit 2 is the most significant |
| result | output | 16 | Selected result |
| carry_out | output | 1 | Adder carry out of bit 15 |

## Verification
Every result and the carry-out are due in the same cycle as the stimulus, because no register lies on any path. The bench changes the inputs just after a rising clock edge. It compares result and carry_out with its behavioural model at the following falling edge, after the whole carry chain has settled. It covers every function code with random operands and random control bits. Directed cases cover the full-length carry ripple, the shift-in bits and the two ways of forming A AND NOT B.

// File: rtl/alu_pkg.sv
// Package: shared function-code type for the bit-slice ALU.
// Assumes: codes are decoded with bit 2 as the most significant bit.
package alu_pkg;

    typedef enum logic [2:0] {
        FN_AND  = 3'b000,
        FN_OR   = 3'b001,
        FN_NAND = 3'b010,
        FN_NOR  = 3'b011,
        FN_SHL  = 3'b100,
        FN_ADD  = 3'b101,
        FN_SHR  = 3'b110,
        FN_PASS = 3'b111
    } alu_fn_e;

endpackage

// File: rtl/alu_operand_cond.sv
// Module: gates and optionally inverts one operand bit.
// Assumes: pure combinational logic; out = (bit AND en) XOR inv.
module alu_operand_cond (
    input  logic bit_in,
    input  logic en,
    input  logic inv,
    output logic bit_out
);

    // Gate the bit, then invert it on request.
    always_comb begin
        bit_out = (bit_in & en) ^ inv;
    end

endmodule

// File: rtl/alu_full_adder.sv
// Module: one-bit full adder used by each slice.
// Assumes: pure combinational logic.
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);

    // Sum and majority carry.
    always_comb begin
        sum  = x ^ y ^ cin;
        cout = (x & y) | (cin & (x ^ y));
    end

endmodule

// File: rtl/alu_slice.sv
// Module: one bit of the ALU. Conditions both operands, forms logic, sum
// and shift candidates, and selects one by function code.
// Assumes: neighbour bits (carry, shift-ins) are wired up by the parent.
module alu_slice
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    a_en,
    input  logic    a_inv,
    input  logic    b_en,
    input  logic    b_inv,
    input  logic    c_in,
    input  logic    lsh_in,
    input  logic    rsh_in,
    input  alu_fn_e fn,
    output logic    a_cond,
    output logic    b_cond,
    output logic    c_out,
    output logic    y
);

    logic sum_bit;

    alu_operand_cond u_cond_a (
        .bit_in (a_bit),
        .en     (a_en),
        .inv    (a_inv),
        .bit_out(a_cond)
    );

    alu_operand_cond u_cond_b (
        .bit_in (b_bit),
        .en     (b_en),
        .inv    (b_inv),
        .bit_out(b_cond)
    );

    alu_full_adder u_fa (
        .x   (a_cond),
        .y   (b_cond),
        .cin (c_in),
        .sum (sum_bit),
        .cout(c_out)
    );

    // Eight-way output selection by function code.
    always_comb begin
        unique case (fn)
            FN_AND:  y = a_cond & b_cond;
            FN_OR:   y = a_cond | b_cond;
            FN_NAND: y = ~(a_cond & b_cond);
            FN_NOR:  y = ~(a_cond | b_cond);
            FN_SHL:  y = lsh_in;
            FN_ADD:  y = sum_bit;
            FN_SHR:  y = rsh_in;
            FN_PASS: y = a_cond;
            default: y = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitslice_alu.sv
// Module: WIDTH-bit ALU made of chained one-bit slices.
// Carry and left shift move upward from bit 0. Right shift moves downward
// from the top bit. Purely combinational.
// Assumes: WIDTH >= 2.
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             op_a_en,
    input  logic             op_a_inv,
    input  logic             op_b_en,
    input  logic             op_b_inv,
    input  logic             carry_in,
    input  logic             rshift_in,
    input  logic [2:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int TOP = WIDTH - 1;

    alu_fn_e fn;
    assign fn = alu_fn_e'(func_sel);

    // Per-slice link wires, kept as separate signals for each bit.
    genvar i;
    for (i = 0; i < WIDTH; i++) begin : g_w
        logic c_in;
        logic c_out;
        logic lsh_in;
        logic rsh_in;
        logic a_c;
        logic b_c;
    end

    for (i = 0; i < WIDTH; i++) begin : g_slice
        // Carry and left-shift come from the slice below; bit 0 takes the edge values.
        if (i == 0) begin : g_lo
            assign g_w[i].c_in   = carry_in;
            assign g_w[i].lsh_in = 1'b0;
        end else begin : g_mid_lo
            assign g_w[i].c_in   = g_w[i-1].c_out;
            assign g_w[i].lsh_in = g_w[i-1].b_c;
        end
        // Right-shift comes from the slice above; the top bit takes rshift_in.
        if (i == TOP) begin : g_hi
            assign g_w[i].rsh_in = rshift_in;
        end else begin : g_mid_hi
            assign g_w[i].rsh_in = g_w[i+1].a_c;
        end

        alu_slice u_slice (
            .a_bit (a[i]),
            .b_bit (b[i]),
            .a_en  (op_a_en),
            .a_inv (op_a_inv),
            .b_en  (op_b_en),
            .b_inv (op_b_inv),
            .c_in  (g_w[i].c_in),
            .lsh_in(g_w[i].lsh_in),
            .rsh_in(g_w[i].rsh_in),
            .fn    (fn),
            .a_cond(g_w[i].a_c),
            .b_cond(g_w[i].b_c),
            .c_out (g_w[i].c_out),
            .y     (result[i])
        );
    end

    assign carry_out = g_w[TOP].c_out;

    // Checks: whole-word arithmetic view compared with the slice chain.
    logic [WIDTH-1:0] chk_a;
    logic [WIDTH-1:0] chk_b;
    logic [WIDTH:0]   chk_sum;

    // Word-level operands and sum for the checks below.
    always_comb begin
        chk_a   = (a & {WIDTH{op_a_en}}) ^ {WIDTH{op_a_inv}};
        chk_b   = (b & {WIDTH{op_b_en}}) ^ {WIDTH{op_b_inv}};
        chk_sum = {1'b0, chk_a} + {1'b0, chk_b} + {{WIDTH{1'b0}}, carry_in};
    end

    // Compare the chain outputs with the word-level view.
    always_comb begin
        assert_carry_R5: assert (carry_out == chk_sum[WIDTH])
            else $error("carry_out differs from word-level carry");
        if (func_sel == 3'b101) begin
            assert_sum_R4: assert (result == chk_sum[TOP:0])
                else $error("sum differs from word-level addition");
        end
        if (func_sel == 3'b100) begin
            assert_shl_R6: assert (result == {chk_b[TOP-1:0], 1'b0})
                else $error("left shift mismatch");
        end
        if (func_sel == 3'b110) begin
            assert_shr_R7: assert (result == {rshift_in, chk_a[TOP:1]})
                else $error("right shift mismatch");
        end
        if (func_sel == 3'b111) begin
            assert_pass_R8: assert (result == chk_a)
                else $error("pass-through mismatch");
        end
    end

endmodule

// File: tb/tb_bitslice_alu.sv
// Bench: drives the ALU just after each rising edge and compares it with a
// behavioural model at the falling edge of the same cycle.
module tb_bitslice_alu;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0] a, b, result;
    logic ena, inva, enb, invb, cin, rsi, carry_out;
    logic [2:0] sel;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    bitslice_alu #(.WIDTH(W)) dut (
        .a(a), .b(b),
        .op_a_en(ena), .op_a_inv(inva), .op_b_en(enb), .op_b_inv(invb),
        .carry_in(cin), .rshift_in(rsi), .func_sel(sel),
        .result(result), .carry_out(carry_out)
    );

    // Behavioural model: returns {carry, result}.
    function automatic logic [W:0] model(input logic [2:0] s, input logic [W-1:0] ia,
            input logic [W-1:0] ib, input logic ea, input logic xa, input logic eb,
            input logic xb, input logic c, input logic r);
        int unsigned av, bv, tot;
        logic [W-1:0] res;
        av  = ea ? int'(ia) : 0;
        if (xa) av = av ^ 32'hFFFF;
        bv  = eb ? int'(ib) : 0;
        if (xb) bv = bv ^ 32'hFFFF;
        tot = av + bv + (c ? 1 : 0);
        case (s)
            3'd0: res = W'(av & bv);
            3'd1: res = W'(av | bv);
            3'd2: res = W'(~(av & bv));
            3'd3: res = W'(~(av | bv));
            3'd4: res = W'(bv * 2);
            3'd5: res = W'(tot);
            3'd6: res = W'((av / 2) + (r ? 32'h8000 : 0));
            default: res = W'(av);
        endcase
        return {tot >= 32'h10000, res};
    endfunction

    task automatic apply(input logic [2:0] s, input logic [W-1:0] ia, input logic [W-1:0] ib,
            input logic ea, input logic xa, input logic eb, input logic xb,
            input logic c, input logic r, input string tag);
        logic [W:0] exp;
        @(posedge clk); #1;
        sel = s; a = ia; b = ib; ena = ea; inva = xa; enb = eb; invb = xb; cin = c; rsi = r;
        exp = model(s, ia, ib, ea, xa, eb, xb, c, r);
        @(negedge clk);
        n_tests++;
        if ({carry_out, result} !== exp) begin
            n_fail++;
            $display("FAIL %s sel=%b: got c=%b r=%h, expected c=%b r=%h",
                     tag, s, carry_out, result, exp[W], exp[W-1:0]);
        end
    endtask

    // Watchdog: counts a hang as a failure.
    initial begin
        #3000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        sel = 3'd0; a = '0; b = '0; ena = 0; inva = 0; enb = 0; invb = 0; cin = 0; rsi = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: all-zero inputs with AND select give zero, no carry (R2, R5).
        @(negedge clk);
        n_tests++;
        if (result !== '0 || carry_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R2 idle: got c=%b r=%h, expected c=0 r=0000", carry_out, result);
        end
        // Directed: R9 A AND NOT B both ways.
        apply(3'b000, 16'hF0F0, 16'hCCCC, 1, 0, 1, 1, 0, 0, "R9 and-form");
        apply(3'b011, 16'hF0F0, 16'hCCCC, 1, 1, 1, 0, 0, 0, "R9 nor-form");
        // R4/R5: full-length ripple.
        apply(3'b101, 16'hFFFF, 16'h0000, 1, 0, 1, 0, 1, 0, "R4 ripple");
        apply(3'b101, 16'h5C5C, 16'h6A6A, 1, 0, 1, 0, 0, 0, "R4 add");
        // R5: carry-out on a logic code.
        apply(3'b001, 16'h8000, 16'h8000, 1, 0, 1, 0, 0, 0, "R5 carry on OR");
        // R6: doubling drops the top bit.
        apply(3'b100, 16'h0000, 16'hC001, 1, 0, 1, 0, 1, 1, "R6 shl");
        // R7: shift-in fills bit 15.
        apply(3'b110, 16'h8001, 16'h0000, 1, 0, 1, 0, 0, 1, "R7 shr in=1");
        apply(3'b110, 16'h8001, 16'h0000, 1, 0, 1, 0, 0, 0, "R7 logical");
        // R1: disabled and inverted operands.
        apply(3'b111, 16'h1234, 16'h0000, 0, 1, 1, 0, 0, 0, "R1/R8 a off inv");
        apply(3'b111, 16'hBEEF, 16'h0000, 1, 0, 0, 0, 0, 0, "R8 pass");
        apply(3'b010, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 0, 0, "R1/R3 b off nand");
        // Random sweep over every code (R1..R8).
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 200; k++) begin
                logic [7:0] ctl;
                ctl = 8'($urandom);
                apply(3'(s), 16'($urandom), 16'($urandom), ctl[0], ctl[1], ctl[2], ctl[3],
                      ctl[4], ctl[5], "R1 R2 R3 R4 R5 R6 R7 R8 random");
            end
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule